// File: doc/BRIEF.md
# Segment Table Address Translator

This block maps a 14-bit virtual address onto a physical address through a table of four segment descriptors. The two upper address bits pick a descriptor. The twelve lower bits form an offset into that segment. Each descriptor holds a physical base, a bound, a present flag and a write-permission flag. A request that passes every check returns base plus offset. A request that fails returns a zero address together with a two-bit fault code that names the first check that failed.

Software rewrites descriptors one field at a time through a small write port. This lets a segment grow or shrink by changing only its bound, while the base stays where it is. The translation logic is combinational, and its output is captured in one register stage. The answer for each request therefore appears on the cycle after the request.

Top module: `seg_xlate`

## Requirements
- R1: After reset, the descriptors are: index 0 at base 0x4000 with bound 0x700, present, read-only; index 1 at base 0x0000 with bound 0x500, present, writable; index 2 not present, with base 0 and bound 0; index 3 at base 0x2000 with bound 0x1000, present, writable. After reset, `rsp_valid`, `rsp_pa` and `rsp_fault` are all 0.
- R2: The segment index is `va[13:12]` and the offset is `va[11:0]`. A request with no fault returns `rsp_pa` = base + offset.
- R3: The access type `acc` is encoded as 00 fetch, 01 load, 10 store; 11 is handled as a store. A fetch or a load never raises a protection fault.
- R4: The fault code on `rsp_fault` is 00 none, 01 segment not present, 10 offset at or above the bound, 11 store to a read-only segment. When the fault code is not 00, `rsp_pa` is 0.
- R5: When several checks fail, the priority is: not present first, then bound, then protection.
- R6: `rsp_valid` is 1 exactly on the cycle after a cycle in which `req` is 1. `rsp_pa` and `rsp_fault` belong to that request.
- R7: A write with `cfg_field` 00 loads the base from `cfg_data`. A write with 01 loads the bound from `cfg_data[12:0]`. A write with 10 loads the flags: `cfg_data[0]` is writable and `cfg_data[1]` is present. A write changes only the named field of the named descriptor.
- R8: A write made in the same cycle as a request does not affect that request. It applies from the next request onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req | input | 1 | Translation request strobe |
| acc | input | 2 | Access type |
| va | input | 14 | Virtual address |
| cfg_we | input | 1 | Descriptor field write enable |
| cfg_idx | input | 2 | Descriptor index to write |
| cfg_field | input | 2 | Field select: base, bound or flags |
| cfg_data | input | 16 | Write data |
| rsp_valid | output | 1 | Result strobe, one cycle after `req` |
| rsp_pa | output | 16 | Physical address, 0 on a fault |
| rsp_fault | output | 2 | Fault code |

## Verification
The bench builds the block with its default parameters: 2 segment bits, a 12-bit offset and a 16-bit physical address. With these values the reset table matches the four descriptors of R1. The offsets 0x6ff/0x700 and 0x4ff/0x500 sit exactly at the bound edges. The stack segment's bound of 0x1000 covers the full offset range. The narrow widths make every descriptor and both sides of each bound reachable in a short run, including grown and shrunk bounds, a descriptor that is brought into use, and a write that collides with a request.

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int SEG_BITS = 2,
  parameter int OFF_BITS = 12,
  parameter int PA_BITS  = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           req,
  input  logic [1:0]                     acc,
  input  logic [SEG_BITS+OFF_BITS-1:0]   va,
  input  logic                           cfg_we,
  input  logic [SEG_BITS-1:0]            cfg_idx,
  input  logic [1:0]                     cfg_field,
  input  logic [PA_BITS-1:0]             cfg_data,
  output logic                           rsp_valid,
  output logic [PA_BITS-1:0]             rsp_pa,
  output logic [1:0]                     rsp_fault
);
  localparam int VA_W  = SEG_BITS + OFF_BITS;
  localparam int NSEG  = 1 << SEG_BITS;
  localparam int BND_W = OFF_BITS + 1;

  function automatic logic [PA_BITS-1:0] init_base(int i);
    case (i)
      0: return PA_BITS'(16'h4000);
      3: return PA_BITS'(16'h2000);
      default: return '0;
    endcase
  endfunction

  function automatic logic [BND_W-1:0] init_bound(int i);
    case (i)
      0: return BND_W'(13'h0700);
      1: return BND_W'(13'h0500);
      3: return BND_W'(13'h1000);
      default: return '0;
    endcase
  endfunction

  logic [PA_BITS-1:0] base_q [NSEG];
  logic [BND_W-1:0]   bnd_q  [NSEG];
  logic [NSEG-1:0]    vld_q, wr_ok_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSEG; i++) begin
        base_q[i]  <= init_base(i);
        bnd_q[i]   <= init_bound(i);
        vld_q[i]   <= (i != 2) && (i < 4);
        wr_ok_q[i] <= (i == 1) || (i == 3);
      end
    end else if (cfg_we) begin
      case (cfg_field)
        2'b00: base_q[cfg_idx] <= cfg_data;
        2'b01: bnd_q[cfg_idx]  <= cfg_data[BND_W-1:0];
        2'b10: begin
          wr_ok_q[cfg_idx] <= cfg_data[0];
          vld_q[cfg_idx]   <= cfg_data[1];
        end
        default: ;
      endcase
    end
  end

  logic [SEG_BITS-1:0] seg;
  logic [OFF_BITS-1:0] off;
  logic                miss, over, prot;
  logic [1:0]          fault_d;

  assign seg  = va[VA_W-1:OFF_BITS];
  assign off  = va[OFF_BITS-1:0];
  assign miss = !vld_q[seg];
  assign over = {1'b0, off} >= bnd_q[seg];
  assign prot = acc[1] && !wr_ok_q[seg];

  assign fault_d = miss ? 2'b01 : over ? 2'b10 : prot ? 2'b11 : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_pa    <= '0;
      rsp_fault <= 2'b00;
    end else begin
      rsp_valid <= req;
      if (req) begin
        rsp_fault <= fault_d;
        rsp_pa    <= (fault_d == 2'b00) ? base_q[seg] + PA_BITS'(off) : '0;
      end
    end
  end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int PA_BITS = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req,
  input logic [1:0]         acc,
  input logic               rsp_valid,
  input logic [PA_BITS-1:0] rsp_pa,
  input logic [1:0]         rsp_fault
);
  // R6
  resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> rsp_valid);

  // R6
  no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !rsp_valid);

  // R4
  fault_zero_pa_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 2'b00) |-> rsp_pa == '0);

  // R3
  read_no_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !acc[1]) |=> rsp_fault != 2'b11);
endmodule

bind seg_xlate seg_xlate_chk #(.PA_BITS(PA_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .acc(acc),
  .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault)
);

// File: tb/tb_seg_xlate.sv
`timescale 1ns/1ps
module tb_seg_xlate;
  logic        clk = 0, rst_n = 0;
  logic        req = 0, cfg_we = 0;
  logic [1:0]  acc = 0, cfg_idx = 0, cfg_field = 0;
  logic [13:0] va = 0;
  logic [15:0] cfg_data = 0;
  logic        rsp_valid;
  logic [15:0] rsp_pa;
  logic [1:0]  rsp_fault;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  seg_xlate dut (.clk(clk), .rst_n(rst_n), .req(req), .acc(acc), .va(va),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_field(cfg_field), .cfg_data(cfg_data),
    .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault));

  // {acc, va, fault, pa}
  localparam logic [33:0] VEC [10] = '{
    {2'b00, 14'h0000, 2'b00, 16'h4000},  // R2 code start
    {2'b01, 14'h06ff, 2'b00, 16'h46ff},  // R2 last code byte
    {2'b00, 14'h0700, 2'b10, 16'h0000},  // R4 bound edge
    {2'b10, 14'h0010, 2'b11, 16'h0000},  // R3 store to read-only
    {2'b10, 14'h14ff, 2'b00, 16'h04ff},  // R2 data last byte
    {2'b01, 14'h1500, 2'b10, 16'h0000},  // R4 data bound edge
    {2'b01, 14'h2000, 2'b01, 16'h0000},  // R4 absent segment
    {2'b11, 14'h3fff, 2'b00, 16'h2fff},  // R3 code 11 as store, writable
    {2'b00, 14'h3000, 2'b00, 16'h2000},  // R2 stack base
    {2'b10, 14'h0800, 2'b10, 16'h0000}   // R5 bound over protection
  };

  task automatic check(string tag, logic [1:0] f, logic [15:0] pa);
    checks++;
    if (rsp_valid !== 1'b1 || rsp_fault !== f || rsp_pa !== pa) begin
      fails++;
      $display("FAIL %s: got v=%b f=%b pa=%h, expected v=1 f=%b pa=%h",
               tag, rsp_valid, rsp_fault, rsp_pa, f, pa);
    end
  endtask

  task automatic do_req(logic [1:0] a, logic [13:0] v);
    @(negedge clk); req = 1; acc = a; va = v;
    @(negedge clk); req = 0;
  endtask

  task automatic wr(logic [1:0] idx, logic [1:0] fld, logic [15:0] d);
    @(negedge clk); cfg_we = 1; cfg_idx = idx; cfg_field = fld; cfg_data = d;
    @(negedge clk); cfg_we = 0;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (rsp_valid !== 0 || rsp_pa !== 0 || rsp_fault !== 0) begin
      fails++;
      $display("FAIL R1 reset outputs: got v=%b pa=%h f=%b, expected 0 0 0", rsp_valid, rsp_pa, rsp_fault);
    end
    rst_n = 1;
    for (int i = 0; i < 10; i++) begin
      do_req(VEC[i][33:32], VEC[i][31:18]);
      check($sformatf("R1/R2 vector %0d", i), VEC[i][17:16], VEC[i][15:0]);
    end
    @(negedge clk);
    checks++;
    if (rsp_valid !== 0) begin
      fails++;
      $display("FAIL R6 idle: got v=%b, expected 0", rsp_valid);
    end
    // R7 grow data bound only
    wr(2'd1, 2'b01, 16'h0600);
    do_req(2'b01, 14'h1550);
    check("R7 grown bound", 2'b00, 16'h0550);
    do_req(2'b10, 14'h1600);
    check("R7 grown bound edge", 2'b10, 16'h0000);
    // R7 bring entry 2 in use
    wr(2'd2, 2'b10, 16'h0003);
    wr(2'd2, 2'b00, 16'h8000);
    do_req(2'b00, 14'h2010);
    check("R7 zero bound", 2'b10, 16'h0000);
    wr(2'd2, 2'b01, 16'h0100);
    do_req(2'b10, 14'h2010);
    check("R7 new segment", 2'b00, 16'h8010);
    // R7 shrink stack, R8 collision
    wr(2'd3, 2'b01, 16'h0010);
    @(negedge clk); req = 1; acc = 2'b01; va = 14'h300f;
    cfg_we = 1; cfg_idx = 2'd3; cfg_field = 2'b10; cfg_data = 16'h0001;
    @(negedge clk); req = 0; cfg_we = 0;
    check("R8 write same cycle", 2'b00, 16'h200f);
    do_req(2'b10, 14'h3fff);
    check("R5 absent over bound", 2'b01, 16'h0000);
    do_req(2'b01, 14'h1000);
    check("R7 other entry untouched", 2'b00, 16'h0000);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule